// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to fifteen hardware interrupt sources and one software break request for a small 8-bit processor. It chooses one source to serve and hands the processor that source's vector address. Four of the sources are external pins. Each pin passes through a synchronizer and an edge detector, and the active edge of each pin can be selected. The other eleven sources are one-cycle event strobes from internal timers, serial channels, the bus interface unit and the converter.

Each source has a request bit and an enable bit. These sit in two byte-wide register pairs that the processor reads and writes over a small byte bus. A global mask flag, set on every acknowledge, blocks all maskable sources. The processor raises `ack` for one cycle to accept the current winner. On that edge the controller clears the winner's request bit and sets the mask flag. On the following cycle it presents the vector address with a valid strobe.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous active-high reset, every request bit, enable bit and edge-select bit reads 0. The mask flag reads 1. `irq` and `vec_valid` are 0, and `vec_addr` is 16'hFFFC, the reset vector.
- R2: A bus write to a request register (address 0 holds bits 0..7, address 1 holds bits 8..14) ANDs the stored bits with the written byte. Writing 0 clears a bit. Writing 1 never sets a bit.
- R3: The enable bits read back as written, at address 2 (low byte) and address 3 (high byte). Bit 7 of address 1 and bit 7 of address 3 always read 0. Addresses 6 and 7 read 0. Read data appears one cycle after the address is presented.
- R4: Pin k (k=0..3) sets request bit 0, 2, 3 or 4 respectively. It does so on its falling edge when edge-select bit k at address 4 is 0, and on its rising edge when that bit is 1. An edge of the wrong polarity sets nothing.
- R5: Strobe bit j of `evt_in` (j=0..10) sets request bit 1, 5, 6, 7, 8, 9, 10, 11, 12, 13 or 14 respectively.
- R6: A source competes only when its request bit is 1, its enable bit is 1 and the mask flag is 0. `irq` is the registered result of whether any competitor exists.
- R7: Among competitors, the lowest request index wins. The break request ranks below all fifteen hardware sources.
- R8: The vector is 16'hFFFA minus twice the winner's index. The break vector is 16'hFFDC. `vec_addr` and a one-cycle `vec_valid` appear on the clock edge after the one that samples `ack`. An `ack` with no competitor leaves `vec_addr` unchanged and gives no `vec_valid`.
- R9: An accepted `ack` clears the winner's request bit (or the pending break) and sets the mask flag.
- R10: A `brk_req` strobe is latched. It competes regardless of the mask flag and of every enable bit.
- R11: A change of an edge-select bit is judged against the current synchronized pin level. Switching from rising to falling while the pin is low latches a request. Switching from falling to rising while the pin is low does not.
- R12: If a hardware event and a bus clear hit the same request bit in the same cycle, the bit ends up set.
- R13: The mask flag is bit 0 of address 5, readable and writable over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| evt_in | input | 11 | One-cycle strobes from internal event sources |
| brk_req | input | 1 | One-cycle software break strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for `bus_addr` |
| ack | input | 1 | Processor accepts the current winner |
| irq | output | 1 | Registered: a competitor exists |
| vec_addr | output | 16 | Registered vector address of the last accepted source |
| vec_valid | output | 1 | One-cycle strobe when `vec_addr` is updated |

## Verification
The bench sends two sources at once through the priority encoder and checks that each acknowledge takes the lower index and sets the mask. A design with the order reversed would return the A-D vector first. It confirms that break wins while the mask is set but loses to a pending timer once the mask is clear; a design that gated break with the mask would leave `irq` low. It writes ones to request registers, and issues a clear in the same cycle as an event, to catch a controller that lets software set bits or drops a colliding event. It also toggles edge-select bits with a pin held low, to show that the spurious request appears in only one direction. An acknowledge with nothing pending must produce no vector strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_N    = 15;
  localparam int PIN_N    = 4;
  localparam int DW       = 8;
  localparam logic [15:0] VEC_BASE = 16'hFFFA;
  localparam int PIN_POS [PIN_N] = '{0, 2, 3, 4};

  function automatic int pin_of(input int pos);
    int r;
    r = -1;
    for (int k = 0; k < PIN_N; k++)
      if (PIN_POS[k] == pos) r = k;
    return r;
  endfunction

  function automatic int evt_rank(input int pos);
    int r;
    r = 0;
    for (int i = 0; i < pos; i++)
      if (pin_of(i) < 0) r++;
    return r;
  endfunction
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  output logic hit
);
  logic [SYNC_N-1:0] sr;
  logic s, lvl, prev;

  assign s   = sr[SYNC_N-1];
  assign lvl = pol ? s : ~s;
  assign hit = lvl & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[SYNC_N-2:0], pin};
      prev <= lvl;
    end
  end

  // R4
  edge_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && $stable(pol)) |-> (pol ? $rose(s) : $fell(s)));
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N  = 15,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  cand,
  input  logic          brk,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = brk;
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NSRC   = SRC_N,
  parameter int NPIN   = PIN_N,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIN-1:0]      ext_pin,
  input  logic [NSRC-NPIN-1:0] evt_in,
  input  logic                 brk_req,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        rd_data,
  input  logic                 ack,
  output logic                 irq,
  output logic [15:0]          vec_addr,
  output logic                 vec_valid
);
  localparam int HI_W = NSRC - DW;
  localparam int IW   = $clog2(NSRC + 1);

  logic [NSRC-1:0] req, req_n, en, en_n, hw_set, cand, clr;
  logic [NPIN-1:0] pol, pol_n, pin_hit;
  logic            mask, mask_n, brk_pend, brk_n, win_vld, take;
  logic [IW-1:0]   win_idx;
  logic [DW-1:0]   rd_n;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    intc_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .pin(ext_pin[k]), .pol(pol[k]), .hit(pin_hit[k]));
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_map
    if (pin_of(i) >= 0) begin : g_p
      assign hw_set[i] = pin_hit[pin_of(i)];
    end else begin : g_e
      assign hw_set[i] = evt_in[evt_rank(i)];
    end
  end

  assign cand = mask ? '0 : (req & en);

  intc_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
    .cand(cand), .brk(brk_pend), .vld(win_vld), .idx(win_idx));

  assign take = ack & win_vld;
  assign clr  = (take && win_idx != IW'(NSRC)) ? (NSRC'(1) << win_idx) : '0;

  always_comb begin
    req_n  = req;
    en_n   = en;
    pol_n  = pol;
    mask_n = mask;
    brk_n  = brk_pend;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: req_n[DW-1:0]    = req[DW-1:0] & bus_wdata;
        3'd1: req_n[NSRC-1:DW] = req[NSRC-1:DW] & bus_wdata[HI_W-1:0];
        3'd2: en_n[DW-1:0]     = bus_wdata;
        3'd3: en_n[NSRC-1:DW]  = bus_wdata[HI_W-1:0];
        3'd4: pol_n            = bus_wdata[NPIN-1:0];
        3'd5: mask_n           = bus_wdata[0];
        default: ;
      endcase
    end
    if (take) begin
      mask_n = 1'b1;
      if (win_idx == IW'(NSRC)) brk_n = 1'b0;
    end
    req_n = (req_n & ~clr) | hw_set;
    brk_n = brk_n | brk_req;
  end

  always_comb begin
    case (bus_addr)
      3'd0: rd_n = req[DW-1:0];
      3'd1: rd_n = DW'(req[NSRC-1:DW]);
      3'd2: rd_n = en[DW-1:0];
      3'd3: rd_n = DW'(en[NSRC-1:DW]);
      3'd4: rd_n = DW'(pol);
      3'd5: rd_n = DW'(mask);
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req       <= '0;
      en        <= '0;
      pol       <= '0;
      mask      <= 1'b1;
      brk_pend  <= 1'b0;
      irq       <= 1'b0;
      rd_data   <= '0;
      vec_addr  <= VEC_BASE + 16'd2;
      vec_valid <= 1'b0;
    end else begin
      req       <= req_n;
      en        <= en_n;
      pol       <= pol_n;
      mask      <= mask_n;
      brk_pend  <= brk_n;
      irq       <= win_vld;
      rd_data   <= rd_n;
      vec_valid <= take;
      if (take) vec_addr <= VEC_BASE - {11'd0, win_idx, 1'b0};
    end
  end

  // R2
  req_set_only_hw_chk: assert property (@(posedge clk) disable iff (rst)
    ((req & ~$past(req) & ~$past(hw_set)) == '0));
  // R9
  ack_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> mask);
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask && !brk_pend) |-> !win_vld);
  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (win_vld && win_idx != IW'(NSRC)) |->
      (cand[win_idx] && ((cand & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0)));
  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFDC));
endmodule

// File: tb/prio_vec_intc_tb_top.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  logic        clk = 0, rst = 1;
  logic [3:0]  ext_pin = 0;
  logic [10:0] evt_in = 0;
  logic        brk_req = 0, bus_wr = 0, ack = 0;
  logic [2:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0, rd_data;
  logic        irq, vec_valid;
  logic [15:0] vec_addr;
  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  r;

  always #2 clk = ~clk;

  prio_vec_intc dut_i (.clk(clk), .rst(rst), .ext_pin(ext_pin), .evt_in(evt_in),
    .brk_req(brk_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .ack(ack), .irq(irq), .vec_addr(vec_addr), .vec_valid(vec_valid));

  task automatic chk(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_evt(input logic [10:0] m);
    evt_in = m;
    @(negedge clk);
    evt_in = 0;
  endtask

  task automatic pulse_brk();
    brk_req = 1;
    @(negedge clk);
    brk_req = 0;
  endtask

  // driver: pushes the expected vector, then acknowledges
  task automatic do_ack(input bit expect_vec, input logic [15:0] v);
    if (expect_vec) exp_q.push_back(v);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  // monitor: compares each produced vector against the queue
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) chk("R8 unexpected vector", vec_addr, 16'hxxxx);
      else chk("R8 vector", vec_addr, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(4);
    rst = 0;
    // R1 reset state
    chk("R1 irq", 16'(irq), 0);
    chk("R1 vec_addr", vec_addr, 16'hFFFC);
    chk("R1 vec_valid", 16'(vec_valid), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r); chk("R1 reg", 16'(r), 0);
    end
    rd(5, r); chk("R1 mask", 16'(r), 1);
    // R2 writing ones sets nothing
    wr(0, 8'hFF); rd(0, r); chk("R2 ones no set", 16'(r), 0);
    // R3 enables
    wr(2, 8'hA5); rd(2, r); chk("R3 en lo", 16'(r), 16'hA5);
    wr(3, 8'hFF); rd(3, r); chk("R3 en hi bit7", 16'(r), 16'h7F);
    rd(6, r); chk("R3 unused addr", 16'(r), 0);
    wr(2, 8'hFF);
    // R5 events: evt 2 -> bit 6 (timer X), evt 10 -> bit 14 (A-D)
    pulse_evt(11'h404);
    rd(0, r); chk("R5 req lo", 16'(r), 16'h40);
    rd(1, r); chk("R5 req hi", 16'(r), 16'h40);
    chk("R6 masked irq", 16'(irq), 0);
    wr(0, 8'hFF); rd(0, r); chk("R2 keep on ones", 16'(r), 16'h40);
    // R13 mask, R6 irq
    wr(5, 8'h00); rd(5, r); chk("R13 mask clr", 16'(r), 0);
    tick(1); chk("R6 irq", 16'(irq), 1);
    // R7 timer X (6) before A-D (14)
    do_ack(1, 16'hFFEE);
    rd(5, r); chk("R9 mask set", 16'(r), 1);
    rd(0, r); chk("R9 req cleared", 16'(r), 0);
    wr(5, 8'h00);
    do_ack(1, 16'hFFDE);
    rd(1, r); chk("R9 A-D cleared", 16'(r), 0);
    // R6 enable gating
    wr(3, 8'h00);
    pulse_evt(11'h010);
    wr(5, 8'h00); tick(2);
    chk("R6 disabled irq", 16'(irq), 0);
    rd(1, r); chk("R5 timer1 bit8", 16'(r), 16'h01);
    wr(1, 8'h00); rd(1, r); chk("R2 clear", 16'(r), 0);
    // R4 pins
    ext_pin[1] = 1; tick(4);
    rd(0, r); chk("R4 wrong edge", 16'(r), 0);
    ext_pin[1] = 0; tick(4);
    rd(0, r); chk("R4 falling INT1", 16'(r), 16'h04);
    wr(4, 8'h04);
    ext_pin[2] = 1; tick(4);
    rd(0, r); chk("R4 rising INT2", 16'(r), 16'h0C);
    chk("R6 irq pins", 16'(irq), 1);
    do_ack(1, 16'hFFF6);
    wr(5, 8'h00);
    do_ack(1, 16'hFFF4);
    rd(0, r); chk("R9 pins cleared", 16'(r), 0);
    // R10 break ignores mask
    wr(3, 8'h7F);
    pulse_evt(11'h010);
    pulse_brk(); tick(1);
    chk("R10 irq under mask", 16'(irq), 1);
    do_ack(1, 16'hFFDC);
    rd(1, r); chk("R10 timer1 kept", 16'(r), 16'h01);
    // R7 break ranks last
    wr(5, 8'h00);
    pulse_brk();
    do_ack(1, 16'hFFEA);
    wr(5, 8'h00);
    do_ack(1, 16'hFFDC);
    // R8 ack with nothing
    do_ack(0, 16'h0000);
    tick(2);
    chk("R8 vec held", vec_addr, 16'hFFDC);
    // R11 edge-select change
    wr(4, 8'h05); tick(3);
    rd(0, r); chk("R11 no spurious", 16'(r), 0);
    wr(4, 8'h04); tick(3);
    rd(0, r); chk("R11 spurious", 16'(r), 16'h01);
    // R12 set beats clear
    bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00; evt_in = 11'h010;
    @(negedge clk);
    bus_wr = 0; evt_in = 0;
    rd(1, r); chk("R12 set wins", 16'(r), 16'h01);
    tick(2);
    chk("R8 queue drained", 16'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule